// File: doc/BRIEF.md
# Charge ADC Gate and Conversion Sequencer

This block is the timing core of a multi-channel charge-integrating ADC module. It decides when the integrators may collect charge and when a conversion may begin. An external gate pulse, a clear level, a crate inhibit line and a crate command strobe with function and subaddress codes come in. Out of the block come the front-end clear release, the ADC integration window, a one-cycle pedestal-injection pulse, a one-cycle conversion start, a busy flag, a ready flag and the command acknowledge (Q).

After power-on the sequencer will not integrate until a clear has been applied. Once it is ready, the rising edge of the synchronized gate opens the window, and the falling edge ends it and starts conversion. The block stays busy until the converter reports done. A matching crate command opens a built-in test window of fixed length instead. A clear that arrives while a cycle is in progress abandons that cycle. The block then refuses new gates for a recovery interval. The gate and inhibit inputs are asynchronous and are synchronized inside. The clear, command and done inputs are synchronous to the clock.

Top module: `qadc_gate_seq`

## Requirements
- R1: After reset `ready`, `busy`, `adc_gate` and `q_resp` are 0, and gates and test commands are ignored. A cycle with `clear_in` high moves the block to ready on the next clock edge.
- R2: A gate rising edge is accepted only when the block is ready, `clear_in` is low and the filtered inhibit is inactive. `adc_gate` rises on the third clock edge after `gate_in` rises.
- R3: Inhibit blocks gates only after the synchronized `inhibit_in` has been high for INH_FILT_CYC (default 10) consecutive cycles. A shorter pulse has no effect.
- R4: For an accepted external gate, `adc_gate` and `fe_clear_rel` stay high for exactly as many cycles as `gate_in` was high. `ped_inj_en` is high for only the first of those cycles.
- R5: In the cycle after the gate window closes, `conv_start` pulses for one cycle and `busy` is high. `fe_clear_rel` stays high while busy.
- R6: `conv_done` while busy returns the block to ready on the next edge, with `busy` and `fe_clear_rel` low. `ready`, `busy` and `adc_gate` are never high together.
- R7: `clear_in` during a gate window, test window or conversion abandons the cycle. No `conv_start` follows. `ready` returns exactly LOCKOUT_CYC (default 200) cycles after `clear_in` is released, and gates in that interval are ignored.
- R8: A strobe with function code 25 and subaddress 0, given while ready with `clear_in` low, raises `q_resp` in the same cycle. It then opens `adc_gate` for TEST_GATE_CYC (default 55) cycles without a pedestal pulse, and a conversion start follows as in R5. Any other code, or any other state, gives `q_resp` low and no window.
- R9: A gate that rises while the block is not ready is dropped, not queued. If it is still high when the block becomes ready, it opens no window.
- R10: If an accepted gate rise and a test strobe fall in the same cycle, the gate wins and `q_resp` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_in | input | 1 | External gate, asynchronous |
| clear_in | input | 1 | Clear level, synchronous |
| inhibit_in | input | 1 | Crate inhibit line, asynchronous |
| cmd_strobe | input | 1 | Crate command strobe, one cycle |
| cmd_func | input | FUNC_W | Command function code |
| cmd_addr | input | ADDR_W | Command subaddress |
| conv_done | input | 1 | Converter finished and stored results |
| fe_clear_rel | output | 1 | Release clear on the front ends |
| adc_gate | output | 1 | ADC integration window |
| ped_inj_en | output | 1 | Pedestal injection pulse at window start |
| conv_start | output | 1 | One-cycle conversion start |
| busy | output | 1 | Conversion in progress |
| ready | output | 1 | Block can accept a gate or test command |
| q_resp | output | 1 | Command accepted (Q) |

## Verification
The assertions assume three things about the inputs. `conv_done` is meaningful only while busy. `clear_in` is a clean synchronous level. The command fields are stable during the strobe cycle. The bench drives every synchronous input just after the falling clock edge. It pulses `conv_done` only once `busy` has been seen. It holds the asynchronous gate and inhibit for whole clock periods, so each synchronizer sees a clean level. The random gate widths, command codes and idle gaps all stay inside these limits.

// File: rtl/qadc_seq_pkg.sv
// Package: shared state encoding for the charge ADC gate sequencer.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package qadc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,  // not yet cleared after power-on
        ST_READY = 3'd1,  // idle, can accept gate or test command
        ST_GATE  = 3'd2,  // external gate window open
        ST_TEST  = 3'd3,  // internal fixed-length test window open
        ST_BUSY  = 3'd4,  // conversion in progress
        ST_LOCK  = 3'd5   // recovery after clear mid-cycle
    } seq_state_t;

endpackage

// File: rtl/qadc_sync2.sv
// Module: two-flop synchronizer for a vector of independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is provided across bits.
module qadc_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Purpose: shift asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/qadc_inh_filter.sv
// Module: integrating filter on the synchronized inhibit line.
// The output becomes active only after the input has been high for HOLD_CYC
// consecutive cycles, and drops as soon as the input goes low.
// Assumes the input is already synchronous to clk.
module qadc_inh_filter #(
    parameter int HOLD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inh_sync,
    output logic inh_active
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] hold_cnt;

    // Purpose: count consecutive high cycles, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!inh_sync) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CNT_FULL) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign inh_active = (hold_cnt == CNT_FULL);

endmodule

// File: rtl/qadc_seq_fsm.sv
// Module: control state machine of the gate sequencer.
// It owns the power-on/ready/busy states, the fixed test window timer
// and the post-clear lockout timer.
// Assumes gate edges are single-cycle pulses from synchronized logic and
// that clear, command hit and conv_done are synchronous to clk.
module qadc_seq_fsm
    import qadc_seq_pkg::*;
#(
    parameter int TEST_GATE_CYC = 55,
    parameter int LOCKOUT_CYC   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_rise,
    input  logic gate_fall,
    input  logic clear_in,
    input  logic inh_active,
    input  logic cmd_hit,
    input  logic conv_done,
    output logic fe_clear_rel,
    output logic adc_gate,
    output logic ped_inj_en,
    output logic conv_start,
    output logic busy,
    output logic ready,
    output logic q_resp
);

    localparam int TMR_MAX = (TEST_GATE_CYC > LOCKOUT_CYC) ? TEST_GATE_CYC : LOCKOUT_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] TEST_LOAD = TMR_W'(TEST_GATE_CYC - 1);
    localparam logic [TMR_W-1:0] LOCK_LOAD = TMR_W'(LOCKOUT_CYC - 1);

    seq_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             acc_gate, acc_test, start_d;
    logic             ped_q, start_q;

    // Purpose: next-state, timer and acceptance decisions.
    always_comb begin
        state_d  = state_q;
        tmr_d    = tmr_q;
        acc_gate = 1'b0;
        acc_test = 1'b0;
        start_d  = 1'b0;
        case (state_q)
            ST_OFF: begin
                if (clear_in) state_d = ST_READY;
            end
            ST_READY: begin
                if (gate_rise && !clear_in && !inh_active) begin
                    acc_gate = 1'b1;
                    state_d  = ST_GATE;
                end else if (cmd_hit && !clear_in) begin
                    acc_test = 1'b1;
                    state_d  = ST_TEST;
                    tmr_d    = TEST_LOAD;
                end
            end
            ST_GATE: begin
                if (clear_in) begin
                    state_d = ST_LOCK;
                    tmr_d   = LOCK_LOAD;
                end else if (gate_fall) begin
                    state_d = ST_BUSY;
                    start_d = 1'b1;
                end
            end
            ST_TEST: begin
                if (clear_in) begin
                    state_d = ST_LOCK;
                    tmr_d   = LOCK_LOAD;
                end else if (tmr_q == '0) begin
                    state_d = ST_BUSY;
                    start_d = 1'b1;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_BUSY: begin
                if (clear_in) begin
                    state_d = ST_LOCK;
                    tmr_d   = LOCK_LOAD;
                end else if (conv_done) begin
                    state_d = ST_READY;
                end
            end
            ST_LOCK: begin
                if (clear_in) begin
                    tmr_d = LOCK_LOAD;
                end else if (tmr_q == '0) begin
                    state_d = ST_READY;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // Purpose: state, timer and single-cycle pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            tmr_q   <= '0;
            ped_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            ped_q   <= acc_gate;
            start_q <= start_d;
        end
    end

    assign adc_gate     = (state_q == ST_GATE) || (state_q == ST_TEST);
    assign fe_clear_rel = adc_gate || (state_q == ST_BUSY);
    assign busy         = (state_q == ST_BUSY);
    assign ready        = (state_q == ST_READY);
    assign ped_inj_en   = ped_q;
    assign conv_start   = start_q;
    assign q_resp       = acc_test;

endmodule

// File: rtl/qadc_gate_seq.sv
// Module: top of the charge ADC gate and conversion sequencer.
// Synchronizes gate and inhibit, filters inhibit, finds gate edges,
// decodes the test command and hands all of it to the state machine.
// Assumes clear_in, cmd_* and conv_done are synchronous to clk.
module qadc_gate_seq #(
    parameter int FUNC_W        = 5,
    parameter int ADDR_W        = 4,
    parameter int TEST_FUNC     = 25,
    parameter int TEST_ADDR     = 0,
    parameter int INH_FILT_CYC  = 10,
    parameter int TEST_GATE_CYC = 55,
    parameter int LOCKOUT_CYC   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_in,
    input  logic              clear_in,
    input  logic              inhibit_in,
    input  logic              cmd_strobe,
    input  logic [FUNC_W-1:0] cmd_func,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              conv_done,
    output logic              fe_clear_rel,
    output logic              adc_gate,
    output logic              ped_inj_en,
    output logic              conv_start,
    output logic              busy,
    output logic              ready,
    output logic              q_resp
);

    localparam logic [FUNC_W-1:0] HIT_FUNC = FUNC_W'(TEST_FUNC);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(TEST_ADDR);

    logic [1:0] sync_vec;
    logic       gate_s, inh_s, gate_prev;
    logic       gate_rise, gate_fall, inh_active, cmd_hit;

    qadc_sync2 #(.WIDTH(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({inhibit_in, gate_in}),
        .sync_out (sync_vec)
    );

    assign gate_s = sync_vec[0];
    assign inh_s  = sync_vec[1];

    qadc_inh_filter #(.HOLD_CYC(INH_FILT_CYC)) u_inh (
        .clk        (clk),
        .rst_n      (rst_n),
        .inh_sync   (inh_s),
        .inh_active (inh_active)
    );

    // Purpose: remember last synchronized gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_prev <= 1'b0;
        else        gate_prev <= gate_s;
    end

    assign gate_rise = gate_s && !gate_prev;
    assign gate_fall = !gate_s && gate_prev;
    assign cmd_hit   = cmd_strobe && (cmd_func == HIT_FUNC) && (cmd_addr == HIT_ADDR);

    qadc_seq_fsm #(
        .TEST_GATE_CYC (TEST_GATE_CYC),
        .LOCKOUT_CYC   (LOCKOUT_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .gate_rise    (gate_rise),
        .gate_fall    (gate_fall),
        .clear_in     (clear_in),
        .inh_active   (inh_active),
        .cmd_hit      (cmd_hit),
        .conv_done    (conv_done),
        .fe_clear_rel (fe_clear_rel),
        .adc_gate     (adc_gate),
        .ped_inj_en   (ped_inj_en),
        .conv_start   (conv_start),
        .busy         (busy),
        .ready        (ready),
        .q_resp       (q_resp)
    );

endmodule

// File: rtl/qadc_gate_seq_chk.sv
// Module: property checker for the gate sequencer, bound to every instance.
// Assumes conv_done is only meaningful while busy and clear_in is synchronous.
module qadc_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic clear_in,
    input logic conv_done,
    input logic fe_clear_rel,
    input logic adc_gate,
    input logic ped_inj_en,
    input logic conv_start,
    input logic busy,
    input logic ready,
    input logic q_resp
);

    AST_GATE_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_gate) |-> $past(ready)); // R2

    AST_PED_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ped_inj_en |-> (adc_gate && $rose(adc_gate))); // R4

    AST_START_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (busy && fe_clear_rel && !adc_gate && $past(adc_gate))); // R5

    AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && !clear_in) |=> (ready && !fe_clear_rel)); // R6

    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ready, busy, adc_gate}) <= 1); // R6

    AST_CLEAR_ABANDONS: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy || adc_gate) && clear_in) |=> (!busy && !ready && !adc_gate && !conv_start)); // R7

    AST_Q_OPENS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        q_resp |=> (adc_gate && !ped_inj_en)); // R8

endmodule

bind qadc_gate_seq qadc_gate_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_in     (clear_in),
    .conv_done    (conv_done),
    .fe_clear_rel (fe_clear_rel),
    .adc_gate     (adc_gate),
    .ped_inj_en   (ped_inj_en),
    .conv_start   (conv_start),
    .busy         (busy),
    .ready        (ready),
    .q_resp       (q_resp)
);

// File: tb/qadc_gate_seq_bench.sv
// Bench: directed corner cases plus seeded random gates and commands.
module qadc_gate_seq_bench;

    localparam int INH_N  = 10;
    localparam int TEST_N = 55;
    localparam int LOCK_N = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_in = 1'b0, clear_in = 1'b0, inhibit_in = 1'b0;
    logic       cmd_strobe = 1'b0, conv_done = 1'b0;
    logic [4:0] cmd_func = '0;
    logic [3:0] cmd_addr = '0;
    logic       fe_clear_rel, adc_gate, ped_inj_en, conv_start, busy, ready, q_resp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qadc_gate_seq u_qadc_gate_seq (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .clear_in(clear_in),
        .inhibit_in(inhibit_in), .cmd_strobe(cmd_strobe), .cmd_func(cmd_func),
        .cmd_addr(cmd_addr), .conv_done(conv_done), .fe_clear_rel(fe_clear_rel),
        .adc_gate(adc_gate), .ped_inj_en(ped_inj_en), .conv_start(conv_start),
        .busy(busy), .ready(ready), .q_resp(q_resp)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_q(input int f, input int a, input bit rdy);
        return (f == 25) && (a == 0) && rdy;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Gate of width w cycles; counts window, pedestal, start and ready cycles.
    task automatic gate_pulse(input int w, output int gc, output int pc, output int sc, output int rc);
        gc = 0; pc = 0; sc = 0; rc = 0;
        gate_in = 1'b1;
        for (int i = 0; i < w + 5; i++) begin
            @(negedge clk);
            gc += adc_gate; pc += ped_inj_en; sc += conv_start; rc += ready;
            if (i == w - 1) gate_in = 1'b0;
        end
    endtask

    // Test command; returns Q and window/pedestal/start counts.
    task automatic test_cmd(input int f, input int a, output bit q, output int gc, output int pc, output int sc);
        gc = 0; pc = 0; sc = 0;
        cmd_func = 5'(f); cmd_addr = 4'(a); cmd_strobe = 1'b1;
        #1 q = q_resp;
        for (int i = 0; i < TEST_N + 8; i++) begin
            @(negedge clk);
            if (i == 0) cmd_strobe = 1'b0;
            gc += adc_gate; pc += ped_inj_en; sc += conv_start;
        end
    endtask

    task automatic finish_conv(input string tag);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(ready && !busy && !fe_clear_rel, tag, {ready, busy, fe_clear_rel}, 3'b100);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int gc, pc, sc, rc, n, w, f, a;
        bit q, rdy;
        void'($urandom(32'd4242));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(!ready && !busy && !adc_gate && !q_resp, "R1 reset outputs", {ready, busy, adc_gate, q_resp}, 0);
        gate_pulse(4, gc, pc, sc, rc);
        chk(gc == 0, "R1 gate ignored before clear", gc, 0);
        test_cmd(25, 0, q, gc, pc, sc);
        chk(!q && gc == 0, "R1 command ignored before clear", gc + q, 0);
        clear_in = 1'b1;
        @(negedge clk);
        clear_in = 1'b0;
        chk(ready, "R1 ready after clear", ready, 1);

        // R2: latency and acceptance
        gate_in = 1'b1;
        tick(2);
        chk(!adc_gate, "R2 window not open after 2 edges", adc_gate, 0);
        tick(1);
        chk(adc_gate && ped_inj_en && fe_clear_rel, "R2/R4 window open on 3rd edge", adc_gate, 1);
        tick(1);
        chk(!ped_inj_en, "R4 pedestal single cycle", ped_inj_en, 0);
        gate_in = 1'b0;
        tick(3);
        chk(conv_start && busy && !adc_gate, "R5 start after window", {conv_start, busy, adc_gate}, 3'b110);
        tick(1);
        chk(!conv_start && busy && fe_clear_rel, "R5 start one cycle, busy held", conv_start, 0);
        finish_conv("R6 done returns ready");

        // R2: clear held blocks gate
        clear_in = 1'b1;
        gate_pulse(5, gc, pc, sc, rc);
        clear_in = 1'b0;
        chk(gc == 0 && ready, "R2 gate blocked by clear", gc, 0);

        // R3: long inhibit blocks, short inhibit does not
        inhibit_in = 1'b1;
        tick(15);
        gate_pulse(5, gc, pc, sc, rc);
        chk(gc == 0 && ready, "R3 long inhibit blocks gate", gc, 0);
        inhibit_in = 1'b0;
        tick(3);
        inhibit_in = 1'b1;
        tick(INH_N - 4);
        inhibit_in = 1'b0;
        gate_pulse(6, gc, pc, sc, rc);
        chk(gc == 6 && pc == 1 && sc == 1, "R3 short inhibit has no effect", gc, 6);
        finish_conv("R6 after short inhibit");

        // R9: gate during busy not queued
        gate_pulse(3, gc, pc, sc, rc);
        gate_in = 1'b1;
        tick(4);
        finish_conv("R6 done with gate held");
        tick(6);
        chk(!adc_gate && ready, "R9 held gate not queued", adc_gate, 0);
        gate_in = 1'b0;
        tick(4);
        chk(ready && !busy, "R9 late fall ignored", busy, 0);

        // R7: clear during conversion, gate ignored in lockout
        gate_pulse(4, gc, pc, sc, rc);
        clear_in = 1'b1;
        @(negedge clk);
        chk(!busy && !ready, "R7 clear abandons conversion", {busy, ready}, 0);
        clear_in = 1'b0;
        gate_pulse(5, gc, pc, sc, rc);
        chk(gc == 0 && rc == 0, "R7 gate ignored in lockout", gc, 0);
        wait_ready(n);
        chk(n + 10 == LOCK_N, "R7 lockout length after conversion", n + 10, LOCK_N);

        // R7: clear during gate window
        gate_in = 1'b1;
        tick(5);
        clear_in = 1'b1;
        @(negedge clk);
        clear_in = 1'b0;
        gate_in = 1'b0;
        chk(!adc_gate && !ready, "R7 clear closes window", adc_gate, 0);
        sc = 0; n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            sc += conv_start;
            n++;
        end
        chk(n == LOCK_N && sc == 0, "R7 lockout after window, no start", n, LOCK_N);

        // R8: test command accepted
        test_cmd(25, 0, q, gc, pc, sc);
        chk(q && gc == TEST_N && pc == 0 && sc == 1, "R8 test window length", gc, TEST_N);
        chk(busy, "R8 busy after test", busy, 1);
        test_cmd(25, 0, q, gc, pc, sc);
        chk(!q && gc == 0, "R8 no Q while busy", q, 0);
        finish_conv("R6 after test");

        // R10: gate and command in same cycle
        gate_in = 1'b1;
        tick(2);
        cmd_func = 5'd25; cmd_addr = 4'd0; cmd_strobe = 1'b1;
        #1 q = q_resp;
        @(negedge clk);
        cmd_strobe = 1'b0;
        chk(!q && adc_gate && ped_inj_en, "R10 gate wins over command", q, 0);
        tick(3);
        gate_in = 1'b0;
        tick(4);
        chk(busy, "R10 conversion from gate", busy, 1);
        finish_conv("R6 after collision");

        // Random mix
        for (int it = 0; it < 30; it++) begin
            if ($urandom % 2 == 0) begin
                w = 2 + int'($urandom % 40);
                gate_pulse(w, gc, pc, sc, rc);
                chk(gc == w && pc == 1 && sc == 1, "R4 random gate width", gc, w);
                tick(int'($urandom % 20));
                finish_conv("R6 random done");
            end else begin
                f = ($urandom % 3 == 0) ? 25 : int'($urandom % 32);
                a = ($urandom % 2 == 0) ? 0 : int'($urandom % 16);
                rdy = ready;
                test_cmd(f, a, q, gc, pc, sc);
                chk(q == exp_q(f, a, rdy), "R8 random Q", q, exp_q(f, a, rdy));
                chk(gc == (q ? TEST_N : 0), "R8 random test window", gc, q ? TEST_N : 0);
                if (q) finish_conv("R6 random test done");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule